// File: doc/BRIEF.md
# Programmable Interval Counter Pair

This block holds two independent 16-bit down-counters, numbered 0 and 2, behind a byte-wide write port. Each counter is set up by a control word that picks the counter and its mode. Its start value is then loaded through the counter's own data address as two bytes, low byte first. Counting starts when the high byte arrives. The counters step down once per cycle in which the reference tick enable is high. That enable is produced elsewhere at 1.19318 MHz.

In mode 0 a counter counts down to zero once, stops there and raises bit 5 of its status byte. In every other mode it reloads its start value on expiry and runs again, so it produces a periodic event. Each expiry gives a one-cycle pulse on that counter's terminal-count output. A control word with an unsupported select or access field gives a one-cycle error pulse and changes nothing.

Top module: `interval_counter_pair`

## Requirements
- R1: After a synchronous active-low reset, both counts are 0, the status byte is 0x00, and both terminal-count pulses and the error pulse are low.
- R2: A write with `wr_sel`=0 is a control word. Bits 7:6 pick the counter (0 picks counter 0, 2 picks counter 2), and bits 3:1 set that counter's mode. Only the selected counter is affected.
- R3: A control word whose bits 5:4 are not both 1 raises `cmd_err` for exactly one cycle and leaves the mode and the byte pointer of every counter unchanged.
- R4: A control word whose bits 7:6 are 1 or 3 raises `cmd_err` for exactly one cycle and changes no counter.
- R5: A write with `wr_sel`=1 (counter 0) or `wr_sel`=2 (counter 2) is a data byte. The first byte is held as the low byte and leaves the count unchanged. The second byte is the high byte: it loads the count with {high, low} and starts the counter.
- R6: A running counter decrements by one in each cycle with `tick_en` high, and holds its value in cycles without it.
- R7: In mode 0, the tick that takes the count from 1 to 0 stops the counter at 0. It also sets the status byte to 0x20 and pulses that counter's terminal-count bit (`tc_pulse[0]` for counter 0, `tc_pulse[1]` for counter 2) for one cycle. Later ticks leave the count at 0.
- R8: In any mode other than 0, the tick that would take the count from 1 to 0 instead reloads the loaded value and pulses the terminal-count bit for one cycle. The counter keeps running.
- R9: Loading a new count clears that counter's status byte to 0x00.
- R10: A valid control word resets that counter's byte pointer, so the next data byte is taken as the low byte.
- R11: A loaded value of 0 stands for 65536 ticks: the first tick takes the count to 0xFFFF without an expiry.
- R12: When a high-byte load and a tick fall in the same cycle, the load wins and the count equals the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Reference tick enable for counting |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 counter 0 data, 2 counter 2 data, 3 none |
| wr_data | input | 8 | Write byte |
| cnt0_q | output | 16 | Current count of counter 0 |
| cnt2_q | output | 16 | Current count of counter 2 |
| status_q | output | 8 | Status byte of counter 2 (0x20 after a mode 0 expiry) |
| tc_pulse | output | 2 | One-cycle expiry pulse: bit 0 for counter 0, bit 1 for counter 2 |
| cmd_err | output | 1 | One-cycle pulse on an unsupported control word |

## Verification
Every result here comes from one register stage. A write or a tick presented before a rising edge shows up in the count, status, pulse and error outputs just after that edge, and pulses fall back one edge later. The bench drives inputs on the falling edge, holds them through one rising edge, and samples at the next falling edge. Pulse checks take the sample just after the edge that should raise the pulse and again one idle cycle later. Same-cycle collisions (a load together with a tick, or an expiry followed by further ticks) are staged so that each expected value can be counted directly in ticks.

// File: rtl/icp_pkg.sv
// Package: shared widths, write-target codes and status constants for the
// interval counter pair. Assumes byte-wide accesses only.
package icp_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int MODE_W  = 3;
    localparam int NUM_CNT = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_DAT0 = 2'd1,
        SEL_DAT2 = 2'd2,
        SEL_NONE = 2'd3
    } wr_target_e;

    localparam logic [BYTE_W-1:0] STATUS_EXPIRED = 8'h20;
    localparam logic [1:0]        ACCESS_LOHI    = 2'b11;

    // Counter index i (0,1) is selected by control code 2*i (0,2).
    function automatic logic [1:0] sel_code(input int idx);
        return 2'(2 * idx);
    endfunction
endpackage

// File: rtl/icp_decode.sv
// Decodes byte writes into per-counter mode and data strobes and flags
// unsupported control words. Assumes one write per cycle at most.
module icp_decode
    import icp_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [1:0]                   wr_sel,
    input  logic [BYTE_W-1:0]            wr_data,
    output logic [NUM_CNT-1:0]           cfg_we,
    output logic [MODE_W-1:0]            cfg_mode,
    output logic [NUM_CNT-1:0]           dat_we,
    output logic                         cmd_err_q
);
    logic ctrl_wr;
    logic ctrl_ok;

    // Purpose: classify the control word fields.
    always_comb begin
        ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
        ctrl_ok  = (wr_data[5:4] == ACCESS_LOHI) &&
                   ((wr_data[7:6] == sel_code(0)) || (wr_data[7:6] == sel_code(1)));
        cfg_mode = wr_data[3:1];
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_strobe
        localparam wr_target_e DAT_SEL = (i == 0) ? SEL_DAT0 : SEL_DAT2;
        assign cfg_we[i] = ctrl_wr && ctrl_ok && (wr_data[7:6] == sel_code(i));
        assign dat_we[i] = wr_en && (wr_sel == DAT_SEL);
    end

    // Purpose: register a one-cycle error pulse for rejected control words.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_err_q <= 1'b0;
        else        cmd_err_q <= ctrl_wr && !ctrl_ok;
    end

    AST_ERR_NO_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_q |-> ($past(cfg_we) == '0)); // R3
    AST_CFG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_we)); // R4
endmodule

// File: rtl/icp_counter.sv
// One 16-bit down-counter: two-byte load (low then high), one-shot mode 0
// with status and stop, periodic reload in all other modes.
// Assumes cfg_we and dat_we are never high in the same cycle.
module icp_counter
    import icp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 cfg_we,
    input  logic [MODE_W-1:0]    cfg_mode,
    input  logic                 dat_we,
    input  logic [BYTE_W-1:0]    dat,
    output logic [CNT_W-1:0]     count_q,
    output logic [BYTE_W-1:0]    status_q,
    output logic                 tc_q
);
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  reload_q;
    logic [BYTE_W-1:0] lo_q;
    logic              hi_next_q;
    logic              run_q;
    logic              load;
    logic              expire;

    // Purpose: detect a full load and a terminal-count tick.
    always_comb begin
        load   = dat_we && hi_next_q;
        expire = run_q && tick_en && !load && (count_q == CNT_W'(1));
    end

    // Purpose: byte pointer, mode and count state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= '0;
            reload_q  <= '0;
            lo_q      <= '0;
            hi_next_q <= 1'b0;
            run_q     <= 1'b0;
            count_q   <= '0;
            status_q  <= '0;
            tc_q      <= 1'b0;
        end else begin
            tc_q <= expire;
            if (cfg_we) begin
                mode_q    <= cfg_mode;
                hi_next_q <= 1'b0;
            end
            if (dat_we && !hi_next_q) begin
                lo_q      <= dat;
                hi_next_q <= 1'b1;
            end
            if (load) begin
                reload_q  <= {dat, lo_q};
                count_q   <= {dat, lo_q};
                hi_next_q <= 1'b0;
                run_q     <= 1'b1;
                status_q  <= '0;
            end else if (expire) begin
                if (mode_q == '0) begin
                    count_q  <= '0;
                    run_q    <= 1'b0;
                    status_q <= STATUS_EXPIRED;
                end else begin
                    count_q  <= reload_q;
                end
            end else if (run_q && tick_en) begin
                count_q <= count_q - CNT_W'(1);
            end
        end
    end

    AST_LOAD_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (status_q == '0) && !tc_q); // R9
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(count_q)); // R6
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_q && ($past(mode_q) == '0)) |-> (count_q == '0) && (status_q == STATUS_EXPIRED)); // R7
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_q && ($past(mode_q) != '0)) |-> (count_q == reload_q)); // R8
endmodule

// File: rtl/interval_counter_pair.sv
// Top: byte-wide write port in front of counters 0 and 2. The status
// output shows counter 2's status byte. Assumes tick_en is a one-cycle
// enable at the reference rate.
module interval_counter_pair
    import icp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [7:0]        wr_data,
    output logic [15:0]       cnt0_q,
    output logic [15:0]       cnt2_q,
    output logic [7:0]        status_q,
    output logic [1:0]        tc_pulse,
    output logic              cmd_err
);
    logic [NUM_CNT-1:0]            cfg_we;
    logic [NUM_CNT-1:0]            dat_we;
    logic [MODE_W-1:0]             cfg_mode;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    logic [NUM_CNT-1:0][BYTE_W-1:0] stat;

    icp_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .cfg_we   (cfg_we),
        .cfg_mode (cfg_mode),
        .dat_we   (dat_we),
        .cmd_err_q(cmd_err)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        icp_counter u_counter (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .cfg_we  (cfg_we[i]),
            .cfg_mode(cfg_mode),
            .dat_we  (dat_we[i]),
            .dat     (wr_data),
            .count_q (cnt[i]),
            .status_q(stat[i]),
            .tc_q    (tc_pulse[i])
        );
    end

    assign cnt0_q   = cnt[0];
    assign cnt2_q   = cnt[1];
    assign status_q = stat[1];
endmodule

// File: tb/interval_counter_pair_bench.sv
module interval_counter_pair_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [7:0]  wr_data = 8'h00;
    logic [15:0] cnt0_q, cnt2_q;
    logic [7:0]  status_q;
    logic [1:0]  tc_pulse;
    logic        cmd_err;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    interval_counter_pair u_interval_counter_pair (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cnt0_q(cnt0_q), .cnt2_q(cnt2_q),
        .status_q(status_q), .tc_pulse(tc_pulse), .cmd_err(cmd_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: present inputs before a rising edge, sample after it.
    task automatic step(input logic we, input logic [1:0] sel, input logic [7:0] d, input logic tk);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d; tick_en = tk;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd3, 8'h00, 1'b1);
    endtask

    task automatic t_reset;
        chk("R1 cnt0", cnt0_q, 0);
        chk("R1 cnt2", cnt2_q, 0);
        chk("R1 status", status_q, 0);
        chk("R1 tc", tc_pulse, 0);
        chk("R1 err", cmd_err, 0);
    endtask

    task automatic t_oneshot;
        step(1, 2'd0, 8'hB0, 0);              // counter 2, mode 0
        chk("R2 err", cmd_err, 0);
        step(1, 2'd2, 8'h03, 0);
        chk("R5 low only", cnt2_q, 0);
        ticks(1);
        chk("R5 not started", cnt2_q, 0);
        step(1, 2'd2, 8'h00, 0);
        chk("R5 loaded", cnt2_q, 16'd3);
        chk("R2 cnt0 untouched", cnt0_q, 0);
        ticks(1);
        chk("R6 dec", cnt2_q, 16'd2);
        step(0, 2'd3, 8'h00, 0);
        chk("R6 hold", cnt2_q, 16'd2);
        ticks(2);
        chk("R7 zero", cnt2_q, 0);
        chk("R7 status", status_q, 8'h20);
        chk("R7 tc", tc_pulse, 2'b10);
        step(0, 2'd3, 8'h00, 0);
        chk("R7 tc one cycle", tc_pulse, 2'b00);
        ticks(2);
        chk("R7 stopped", cnt2_q, 0);
        step(1, 2'd2, 8'h05, 0);
        step(1, 2'd2, 8'h00, 0);
        chk("R9 status cleared", status_q, 0);
        chk("R9 count", cnt2_q, 16'd5);
    endtask

    task automatic t_periodic;
        step(1, 2'd0, 8'h34, 0);              // counter 0, mode 2
        step(1, 2'd1, 8'h02, 0);
        step(1, 2'd1, 8'h00, 0);
        chk("R2 cnt0 loaded", cnt0_q, 16'd2);
        ticks(1);
        chk("R8 dec", cnt0_q, 16'd1);
        ticks(1);
        chk("R8 reload", cnt0_q, 16'd2);
        chk("R8 tc", tc_pulse, 2'b01);
        ticks(1);
        chk("R8 running", cnt0_q, 16'd1);
        chk("R8 tc low", tc_pulse, 2'b00);
        ticks(1);
        chk("R8 second tc", tc_pulse, 2'b01);
        chk("R8 cnt2 running too", cnt2_q, 16'd1);
    endtask

    task automatic t_bad_cmds;
        step(1, 2'd0, 8'h94, 0);              // counter 2, access 01 -> reject
        chk("R3 err", cmd_err, 1);
        step(0, 2'd3, 8'h00, 0);
        chk("R3 err one cycle", cmd_err, 0);
        ticks(1);                             // cnt2 1 -> 0, still mode 0
        chk("R3 mode kept stop", cnt2_q, 0);
        chk("R3 mode kept status", status_q, 8'h20);
        ticks(1);
        chk("R3 stays stopped", cnt2_q, 0);
        step(1, 2'd0, 8'h74, 0);
        chk("R4 sel1 err", cmd_err, 1);
        step(1, 2'd0, 8'hF4, 0);
        chk("R4 sel3 err", cmd_err, 1);
        chk("R4 cnt0 unchanged", cnt0_q, 16'd2);
    endtask

    task automatic t_pointer;
        step(1, 2'd1, 8'h09, 0);              // low byte pending
        step(1, 2'd0, 8'h34, 0);              // resets pointer
        step(1, 2'd1, 8'h04, 0);
        step(1, 2'd1, 8'h00, 0);
        chk("R10 pointer reset", cnt0_q, 16'h0004);
    endtask

    task automatic t_zero_and_collide;
        step(1, 2'd0, 8'hB0, 0);
        step(1, 2'd2, 8'h00, 0);
        step(1, 2'd2, 8'h00, 0);
        ticks(1);
        chk("R11 wrap", cnt2_q, 16'hFFFF);
        chk("R11 no tc", tc_pulse, 2'b00);
        step(1, 2'd1, 8'h07, 0);
        step(1, 2'd1, 8'h00, 1);
        chk("R12 load wins", cnt0_q, 16'h0007);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oneshot();
        t_periodic();
        t_bad_cmds();
        t_pointer();
        t_zero_and_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule